// File: doc/BRIEF.md
# Multicycle MIPS control unit

This block sequences a multicycle processor for a small MIPS integer subset (add, sub, and, or, slt, lw, sw, beq, addi, j) whose datapath uses one memory for both instructions and data. A Moore state machine walks each instruction through a series of states and emits a fixed control word from each state. The word carries the memory address source, the memory write, the instruction-register load, the register-file destination and write-back source, the register write, the two ALU operand selects and the next-PC source. A separate ALU decoder turns the state's 2-bit ALU operation class and the instruction's 6-bit funct field into a 3-bit ALU control code. A small gate combines the unconditional PC update with the branch condition and the ALU zero flag to form the PC enable.

The states are: Fetch, Decode, MemAddr, MemRead, LoadWb, MemStore, RExec, RWb, Branch, ImmExec, ImmWb and Jump. The transitions are: Fetch to Decode; Decode to MemAddr (lw, sw), RExec (R-type), Branch (beq), ImmExec (addi), Jump (j), or back to Fetch for any other opcode; MemAddr to MemRead (lw) or MemStore (sw); MemRead to LoadWb; RExec to RWb; ImmExec to ImmWb; LoadWb, MemStore, RWb, Branch, ImmWb and Jump all return to Fetch. The datapath feeds the opcode and funct from its instruction register and the zero flag from its ALU.

Top module: `mcu_ctrl_top`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, the unit is in Fetch: ir_ld=1, pc_upd=1, pc_en=1, alu_b_sel=01, pc_src_sel=00, alu_ctl=010, and every other output is 0.
- R2: Fetch is always followed by Decode, which drives alu_b_sel=11, alu_a_sel_reg=0, alu_ctl=010 and all enables at 0.
- R3: Opcode 100011 (lw) after Decode gives MemAddr (alu_a_sel_reg=1, alu_b_sel=10, alu_ctl=010), then MemRead (addr_sel_data=1), then LoadWb (rf_we=1, wb_sel_mem=1, dst_sel_rd=0), then Fetch.
- R4: Opcode 101011 (sw) after Decode gives MemAddr, then MemStore (addr_sel_data=1, mem_we=1), then Fetch; memory and register writes never occur in the same cycle.
- R5: Opcode 000000 (R-type) after Decode gives RExec (alu_a_sel_reg=1, alu_b_sel=00, alu_ctl from funct), then RWb (rf_we=1, dst_sel_rd=1, wb_sel_mem=0), then Fetch.
- R6: In RExec the ALU control follows funct: 100000 gives 010, 100010 gives 110, 100100 gives 000, 100101 gives 001, 101010 gives 111, any other funct gives 010.
- R7: Opcode 000100 (beq) after Decode gives Branch (alu_a_sel_reg=1, alu_b_sel=00, alu_ctl=110, pc_src_sel=01, br_cond=1), then Fetch.
- R8: Opcode 001000 (addi) after Decode gives ImmExec (alu_a_sel_reg=1, alu_b_sel=10, alu_ctl=010), then ImmWb (rf_we=1, dst_sel_rd=0, wb_sel_mem=0), then Fetch.
- R9: Opcode 000010 (j) after Decode gives Jump (pc_src_sel=10, pc_upd=1), then Fetch.
- R10: Any other opcode in Decode sends the unit back to Fetch on the next cycle.
- R11: pc_en is high exactly when pc_upd is high or br_cond and alu_zero are both high; alu_zero has no effect in any state other than Branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 6 | Opcode from the instruction register |
| fn | input | 6 | Funct field from the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| addr_sel_data | output | 1 | Memory address from ALU result register (1) or PC (0) |
| mem_we | output | 1 | Memory write enable |
| ir_ld | output | 1 | Instruction register load |
| dst_sel_rd | output | 1 | Destination register from rd field (1) or rt field (0) |
| wb_sel_mem | output | 1 | Register write data from memory data (1) or ALU result (0) |
| rf_we | output | 1 | Register file write enable |
| alu_a_sel_reg | output | 1 | ALU operand A from register (1) or PC (0) |
| alu_b_sel | output | 2 | ALU operand B: 00 register, 01 constant 4, 10 immediate, 11 shifted immediate |
| pc_src_sel | output | 2 | Next PC: 00 ALU, 01 ALU result register, 10 jump target |
| alu_ctl | output | 3 | ALU operation code |
| pc_upd | output | 1 | Unconditional PC write request |
| br_cond | output | 1 | Conditional branch request |
| pc_en | output | 1 | PC register enable |

## Verification
Every supported opcode is run through its whole state walk, and each cycle's full output vector is compared, so a wrong state, a swapped select or an extra enable in any state is caught. R-type instructions are repeated with all five funct codes and one unlisted code, separating the funct decoding from the fixed add and subtract classes. Branch and jump are each run with the zero flag high and low, which tells the conditional PC enable from the unconditional one, and the zero flag is also held high through loads and decode to show it cannot open the PC outside Branch. Two unsupported opcodes show the early return from Decode.

// File: rtl/mcu_ctrl_pkg.sv
`timescale 1ns/1ps
package mcu_ctrl_pkg;

    localparam int OP_W   = 6;
    localparam int FN_W   = 6;
    localparam int ALUC_W = 3;
    localparam int SEL_W  = 2;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_MEM_ADDR,
        ST_MEM_READ,
        ST_LOAD_WB,
        ST_MEM_STORE,
        ST_R_EXEC,
        ST_R_WB,
        ST_BRANCH,
        ST_IMM_EXEC,
        ST_IMM_WB,
        ST_JUMP
    } state_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } aluop_e;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LW    = 6'b100011;
    localparam logic [OP_W-1:0] OPC_SW    = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'b001000;
    localparam logic [OP_W-1:0] OPC_J     = 6'b000010;

    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FN_W-1:0] FN_AND = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

    localparam logic [ALUC_W-1:0] ALUC_AND = 3'b000;
    localparam logic [ALUC_W-1:0] ALUC_OR  = 3'b001;
    localparam logic [ALUC_W-1:0] ALUC_ADD = 3'b010;
    localparam logic [ALUC_W-1:0] ALUC_SUB = 3'b110;
    localparam logic [ALUC_W-1:0] ALUC_SLT = 3'b111;

    localparam logic [SEL_W-1:0] BSEL_REG   = 2'b00;
    localparam logic [SEL_W-1:0] BSEL_FOUR  = 2'b01;
    localparam logic [SEL_W-1:0] BSEL_IMM   = 2'b10;
    localparam logic [SEL_W-1:0] BSEL_IMMSH = 2'b11;

    localparam logic [SEL_W-1:0] PSEL_ALU  = 2'b00;
    localparam logic [SEL_W-1:0] PSEL_AOUT = 2'b01;
    localparam logic [SEL_W-1:0] PSEL_JMP  = 2'b10;

    typedef struct packed {
        logic              addr_data;
        logic              mem_we;
        logic              ir_ld;
        logic              dst_rd;
        logic              wb_mem;
        logic              rf_we;
        logic              a_reg;
        logic [SEL_W-1:0]  b_sel;
        logic [SEL_W-1:0]  pc_sel;
        aluop_e            aop;
        logic              pc_upd;
        logic              br;
    } ctrl_word_t;

    function automatic logic op_supported(input logic [OP_W-1:0] o);
        return (o == OPC_RTYPE) || (o == OPC_LW) || (o == OPC_SW) ||
               (o == OPC_BEQ) || (o == OPC_ADDI) || (o == OPC_J);
    endfunction

endpackage

// File: rtl/mcu_seq_fsm.sv
`timescale 1ns/1ps
module mcu_seq_fsm
    import mcu_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op,
    output ctrl_word_t       cw
);

    state_e state_q;
    state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = ST_FETCH;
        unique case (state_q)
            ST_FETCH:     state_d = ST_DECODE;
            ST_DECODE: begin
                case (op)
                    OPC_LW,
                    OPC_SW:    state_d = ST_MEM_ADDR;
                    OPC_RTYPE: state_d = ST_R_EXEC;
                    OPC_BEQ:   state_d = ST_BRANCH;
                    OPC_ADDI:  state_d = ST_IMM_EXEC;
                    OPC_J:     state_d = ST_JUMP;
                    default:   state_d = ST_FETCH;
                endcase
            end
            ST_MEM_ADDR:  state_d = (op == OPC_SW) ? ST_MEM_STORE : ST_MEM_READ;
            ST_MEM_READ:  state_d = ST_LOAD_WB;
            ST_R_EXEC:    state_d = ST_R_WB;
            ST_IMM_EXEC:  state_d = ST_IMM_WB;
            ST_LOAD_WB,
            ST_MEM_STORE,
            ST_R_WB,
            ST_BRANCH,
            ST_IMM_WB,
            ST_JUMP:      state_d = ST_FETCH;
            default:      state_d = ST_FETCH;
        endcase
    end

    // control word per state
    always_comb begin
        cw        = '0;
        cw.aop    = AOP_ADD;
        cw.b_sel  = BSEL_REG;
        cw.pc_sel = PSEL_ALU;
        unique case (state_q)
            ST_FETCH: begin
                cw.ir_ld  = 1'b1;
                cw.b_sel  = BSEL_FOUR;
                cw.pc_upd = 1'b1;
            end
            ST_DECODE: begin
                cw.b_sel = BSEL_IMMSH;
            end
            ST_MEM_ADDR,
            ST_IMM_EXEC: begin
                cw.a_reg = 1'b1;
                cw.b_sel = BSEL_IMM;
            end
            ST_MEM_READ: begin
                cw.addr_data = 1'b1;
            end
            ST_LOAD_WB: begin
                cw.rf_we  = 1'b1;
                cw.wb_mem = 1'b1;
            end
            ST_MEM_STORE: begin
                cw.addr_data = 1'b1;
                cw.mem_we    = 1'b1;
            end
            ST_R_EXEC: begin
                cw.a_reg = 1'b1;
                cw.aop   = AOP_FUNCT;
            end
            ST_R_WB: begin
                cw.rf_we  = 1'b1;
                cw.dst_rd = 1'b1;
            end
            ST_BRANCH: begin
                cw.a_reg  = 1'b1;
                cw.aop    = AOP_SUB;
                cw.pc_sel = PSEL_AOUT;
                cw.br     = 1'b1;
            end
            ST_IMM_WB: begin
                cw.rf_we = 1'b1;
            end
            ST_JUMP: begin
                cw.pc_sel = PSEL_JMP;
                cw.pc_upd = 1'b1;
            end
            default: ;
        endcase
    end

    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE)) else $error("fetch not followed by decode"); // R2

    AST_UNSUPPORTED_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && !op_supported(op)) |=> (state_q == ST_FETCH)) else $error("bad opcode not dropped"); // R10

    AST_WRITES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cw.mem_we && cw.rf_we)) else $error("memory and register write together"); // R4

    AST_STORE_DATA_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        cw.mem_we |-> cw.addr_data) else $error("store to instruction address"); // R4

endmodule

// File: rtl/mcu_alu_dec.sv
`timescale 1ns/1ps
module mcu_alu_dec
    import mcu_ctrl_pkg::*;
(
    input  aluop_e             aop,
    input  logic [FN_W-1:0]    fn,
    output logic [ALUC_W-1:0]  alu_ctl
);

    logic [ALUC_W-1:0] fn_ctl;

    always_comb begin
        case (fn)
            FN_ADD:  fn_ctl = ALUC_ADD;
            FN_SUB:  fn_ctl = ALUC_SUB;
            FN_AND:  fn_ctl = ALUC_AND;
            FN_OR:   fn_ctl = ALUC_OR;
            FN_SLT:  fn_ctl = ALUC_SLT;
            default: fn_ctl = ALUC_ADD;
        endcase
    end

    always_comb begin
        unique case (aop)
            AOP_ADD:   alu_ctl = ALUC_ADD;
            AOP_SUB:   alu_ctl = ALUC_SUB;
            default:   alu_ctl = fn_ctl;
        endcase
    end

endmodule

// File: rtl/mcu_pc_gate.sv
`timescale 1ns/1ps
module mcu_pc_gate (
    input  logic pc_upd,
    input  logic br,
    input  logic zero,
    output logic pc_en
);

    assign pc_en = pc_upd | (br & zero);

endmodule

// File: rtl/mcu_ctrl_top.sv
`timescale 1ns/1ps
module mcu_ctrl_top
    import mcu_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op,
    input  logic [FN_W-1:0]   fn,
    input  logic              alu_zero,
    output logic              addr_sel_data,
    output logic              mem_we,
    output logic              ir_ld,
    output logic              dst_sel_rd,
    output logic              wb_sel_mem,
    output logic              rf_we,
    output logic              alu_a_sel_reg,
    output logic [SEL_W-1:0]  alu_b_sel,
    output logic [SEL_W-1:0]  pc_src_sel,
    output logic [ALUC_W-1:0] alu_ctl,
    output logic              pc_upd,
    output logic              br_cond,
    output logic              pc_en
);

    ctrl_word_t cw;

    mcu_seq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .cw    (cw)
    );

    mcu_alu_dec u_alu_dec (
        .aop     (cw.aop),
        .fn      (fn),
        .alu_ctl (alu_ctl)
    );

    mcu_pc_gate u_pc_gate (
        .pc_upd (cw.pc_upd),
        .br     (cw.br),
        .zero   (alu_zero),
        .pc_en  (pc_en)
    );

    assign addr_sel_data = cw.addr_data;
    assign mem_we        = cw.mem_we;
    assign ir_ld         = cw.ir_ld;
    assign dst_sel_rd    = cw.dst_rd;
    assign wb_sel_mem    = cw.wb_mem;
    assign rf_we         = cw.rf_we;
    assign alu_a_sel_reg = cw.a_reg;
    assign alu_b_sel     = cw.b_sel;
    assign pc_src_sel    = cw.pc_sel;
    assign pc_upd        = cw.pc_upd;
    assign br_cond       = cw.br;

    AST_FETCH_ADVANCES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ir_ld |-> pc_en) else $error("fetch without PC update"); // R1

    AST_BRANCH_SUBTRACTS: assert property (@(posedge clk) disable iff (!rst_n)
        br_cond |-> (alu_ctl == ALUC_SUB)) else $error("branch compare is not a subtract"); // R7

    AST_TERMINAL_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || mem_we || br_cond || pc_src_sel == PSEL_JMP) |=> ir_ld) else $error("terminal state did not return to fetch"); // R3

    AST_ZERO_ONLY_IN_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_cond && !pc_upd) |-> !pc_en) else $error("zero flag opened PC outside branch"); // R11

endmodule

// File: tb/tb_mcu_ctrl_top.sv
`timescale 1ns/1ps
module tb_mcu_ctrl_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] op_i = 6'b000000;
    logic [5:0] fn_i = 6'b000000;
    logic       zero_i = 1'b0;

    logic       addr_sel_data, mem_we, ir_ld, dst_sel_rd, wb_sel_mem, rf_we;
    logic       alu_a_sel_reg, pc_upd, br_cond, pc_en;
    logic [1:0] alu_b_sel, pc_src_sel;
    logic [2:0] alu_ctl;

    int errors = 0;
    int checks = 0;
    bit need_fetch = 1'b1;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    mcu_ctrl_top dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .op            (op_i),
        .fn            (fn_i),
        .alu_zero      (zero_i),
        .addr_sel_data (addr_sel_data),
        .mem_we        (mem_we),
        .ir_ld         (ir_ld),
        .dst_sel_rd    (dst_sel_rd),
        .wb_sel_mem    (wb_sel_mem),
        .rf_we         (rf_we),
        .alu_a_sel_reg (alu_a_sel_reg),
        .alu_b_sel     (alu_b_sel),
        .pc_src_sel    (pc_src_sel),
        .alu_ctl       (alu_ctl),
        .pc_upd        (pc_upd),
        .br_cond       (br_cond),
        .pc_en         (pc_en)
    );

    function automatic logic [16:0] actual_vec();
        return {addr_sel_data, mem_we, ir_ld, dst_sel_rd, wb_sel_mem, rf_we,
                alu_a_sel_reg, alu_b_sel, pc_src_sel, alu_ctl, pc_upd, br_cond, pc_en};
    endfunction

    // expected word; pc enable follows R11
    function automatic logic [16:0] w(input logic ad, input logic mw, input logic ir,
                                      input logic dr, input logic wm, input logic rw,
                                      input logic ar, input logic [1:0] b, input logic [1:0] ps,
                                      input logic [2:0] ac, input logic pu, input logic br,
                                      input logic z);
        return {ad, mw, ir, dr, wm, rw, ar, b, ps, ac, pu, br, (pu | (br & z))};
    endfunction

    // funct table from R6
    function automatic logic [2:0] exp_alu(input logic [5:0] f);
        case (f)
            6'b100000: return 3'b010;
            6'b100010: return 3'b110;
            6'b100100: return 3'b000;
            6'b100101: return 3'b001;
            6'b101010: return 3'b111;
            default:   return 3'b010;
        endcase
    endfunction

    task automatic push(input logic [16:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic run(input logic [5:0] op, input logic [5:0] fn, input logic z);
        wait (exp_q.size() == 0);
        op_i   = op;
        fn_i   = fn;
        zero_i = z;
        if (need_fetch)
            push(w(0,0,1,0,0,0,0,2'b01,2'b00,3'b010,1,0,z), "R1");
        need_fetch = 1'b1;
        push(w(0,0,0,0,0,0,0,2'b11,2'b00,3'b010,0,0,z), "R2,R11");
        case (op)
            6'b100011: begin
                push(w(0,0,0,0,0,0,1,2'b10,2'b00,3'b010,0,0,z), "R3");
                push(w(1,0,0,0,0,0,0,2'b00,2'b00,3'b010,0,0,z), "R3");
                push(w(0,0,0,0,1,1,0,2'b00,2'b00,3'b010,0,0,z), "R3");
            end
            6'b101011: begin
                push(w(0,0,0,0,0,0,1,2'b10,2'b00,3'b010,0,0,z), "R4");
                push(w(1,1,0,0,0,0,0,2'b00,2'b00,3'b010,0,0,z), "R4");
            end
            6'b000000: begin
                push(w(0,0,0,0,0,0,1,2'b00,2'b00,exp_alu(fn),0,0,z), "R5,R6");
                push(w(0,0,0,1,0,1,0,2'b00,2'b00,3'b010,0,0,z), "R5");
            end
            6'b000100: begin
                push(w(0,0,0,0,0,0,1,2'b00,2'b01,3'b110,0,1,z), "R7,R11");
            end
            6'b001000: begin
                push(w(0,0,0,0,0,0,1,2'b10,2'b00,3'b010,0,0,z), "R8");
                push(w(0,0,0,0,0,1,0,2'b00,2'b00,3'b010,0,0,z), "R8");
            end
            6'b000010: begin
                push(w(0,0,0,0,0,0,0,2'b00,2'b10,3'b010,1,0,z), "R9");
            end
            default: begin
                push(w(0,0,1,0,0,0,0,2'b01,2'b00,3'b010,1,0,z), "R10");
                need_fetch = 1'b0;
            end
        endcase
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // monitor: pops one expected word per cycle, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            logic [16:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (actual_vec() !== e) begin
                errors++;
                $display("FAIL %s: actual=%b expected=%b", t, actual_vec(), e);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        // R1: outputs while reset is held
        repeat (2) @(negedge clk);
        checks++;
        if (actual_vec() !== w(0,0,1,0,0,0,0,2'b01,2'b00,3'b010,1,0,1'b0)) begin
            errors++;
            $display("FAIL R1: actual=%b expected=%b", actual_vec(),
                     w(0,0,1,0,0,0,0,2'b01,2'b00,3'b010,1,0,1'b0));
        end
        run(6'b100011, 6'b000000, 1'b0);       // lw
        @(posedge clk);
        #1 rst_n = 1'b1;
        run(6'b101011, 6'b000000, 1'b0);       // sw
        run(6'b000000, 6'b100000, 1'b0);       // add
        run(6'b000000, 6'b100010, 1'b1);       // sub, zero high
        run(6'b000000, 6'b100100, 1'b0);       // and
        run(6'b000000, 6'b100101, 1'b0);       // or
        run(6'b000000, 6'b101010, 1'b0);       // slt
        run(6'b000000, 6'b000111, 1'b0);       // unlisted funct
        run(6'b000100, 6'b000000, 1'b1);       // beq taken
        run(6'b000100, 6'b000000, 1'b0);       // beq not taken
        run(6'b001000, 6'b000000, 1'b0);       // addi
        run(6'b000010, 6'b000000, 1'b0);       // j
        run(6'b000010, 6'b000000, 1'b1);       // j, zero high
        run(6'b111111, 6'b000000, 1'b1);       // unsupported
        run(6'b000011, 6'b000000, 1'b0);       // unsupported
        run(6'b100011, 6'b000000, 1'b1);       // lw, zero high
        wait (exp_q.size() == 0);
        @(negedge clk);
        summary();
        $finish;
    end

endmodule